// File: doc/BRIEF.md
# Stochastic Training Stimulus Generator

This block feeds the input layer of a single-neuron spiking perceptron that learns without labels. Time is cut into epochs of a fixed number of clock ticks. At the start of each epoch the block presents one stimulus, a spike vector with one bit per input channel, for exactly one tick. A pseudo-random bit decides whether the stimulus is a stored reference pattern or a sparse noise image. In a pattern image all member channels fire in the same tick. In a noise image only a small, programmable share of channels fire. Two pattern epochs never follow each other, because a pattern arriving just after the neuron fired would depress the pattern's own synapses.

In dynamic mode the active reference pattern steps through up to three stored images. It moves on after a programmed number of epochs, so the learning network can be tested on re-adaptation. A start pulse loads the seed and begins a run. The run continues until the next start or reset. Reference patterns are written through a simple write port into a small memory that maps onto block RAM.

Top module: `spike_stim_gen`

## Requirements
- R1: After reset, and until the first start pulse, `spike` is all zeros and `is_pat` is 0. `epoch_cnt` is 0 and stays 0.
- R2: After a start pulse is taken at clock edge E, stimuli are presented at edges E+T, E+2T, and so on, where T is `EPOCH_TICKS`. At every other edge `spike` returns to zero and `epoch_cnt` holds its value.
- R3: Randomness comes from a 16-bit shift register that a start pulse loads from `seed`. A seed of 0 is replaced by 1. One step maps s to {s[14:0], s[15]^s[13]^s[12]^s[10]}. Each presentation advances the register by `N_CH`+1 steps.
- R4: Let the states after steps 1..`N_CH` of an epoch be s1..sN. In a noise image, channel k fires exactly when s(k+1)[7:0] < `noise_thr`. A threshold of 0 gives an empty image.
- R5: The pick bit is bit 0 of the state after step `N_CH`+1. The epoch presents the reference pattern when the pick bit is 1 and the previous epoch was not a pattern. Otherwise it presents the noise image.
- R6: The epoch after a pattern epoch is always noise, so `is_pat` is never 1 in two consecutive presentations.
- R7: A pattern presentation drives every channel of the active stored pattern in the same tick, and sets `is_pat` to 1. `is_pat` holds its value until the next presentation.
- R8: With `dyn_en` low, the active pattern is always slot 0.
- R9: With `dyn_en` high and `sw_epochs` = P > 0, epochs 0..P-1 use slot 0 and the next P epochs use slot 1. The slot index wraps to 0 after `pat_last`. A `pat_last` above the highest slot is treated as the highest slot. A P of 0 never switches.
- R10: `epoch_cnt` rises by one at every presentation, counted since the last start.
- R11: A start pulse clears `spike`, `is_pat` and `epoch_cnt` at the edge where it is taken, and restarts the run. This holds even when that edge is a presentation edge, in which case no stimulus is presented.
- R12: A pattern write that completes at least two edges before a presentation edge is used by that presentation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Loads the seed and begins a new run |
| seed | input | 16 | Initial shift-register state |
| noise_thr | input | 8 | Noise inclusion threshold per channel |
| dyn_en | input | 1 | Enables cycling through reference patterns |
| sw_epochs | input | SW_W | Epochs per pattern in dynamic mode |
| pat_last | input | IW | Highest pattern slot used in dynamic mode |
| pat_wr_en | input | 1 | Pattern memory write strobe |
| pat_wr_idx | input | IW | Pattern slot to write |
| pat_wr_data | input | N_CH | Pattern image to write |
| spike | output | N_CH | One-tick spike vector |
| is_pat | output | 1 | Last presentation was a reference pattern |
| epoch_cnt | output | ECW | Presentations since the last start |

## Verification
Two functions can fall on the same edge: a start pulse and an epoch presentation. The bench provokes this by timing a start pulse so that it is taken exactly at the edge where the running epoch would present its stimulus. It expects the restart to win: no spikes, a cleared flag and a zero count at that edge, then a fresh sequence from the new seed one full epoch later. A second overlap, a pattern write in the middle of an epoch in dynamic mode, is judged by the next pattern presentation of that slot carrying the new image.

// File: rtl/spike_stim_pkg.sv
package spike_stim_pkg;
  localparam int LFSR_W = 16;
  typedef logic [LFSR_W-1:0] lfsr_t;

  // one shift of the maximal-length 16-bit sequence, taps 16,14,13,11
  function automatic lfsr_t lfsr_next(input lfsr_t s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // an all-zero state would lock the sequence
  function automatic lfsr_t seed_fix(input lfsr_t s);
    return (s == '0) ? lfsr_t'(1) : s;
  endfunction
endpackage

// File: rtl/spike_stim_lfsr_fan.sv
module spike_stim_lfsr_fan
  import spike_stim_pkg::*;
#(
  parameter int N_CH = 16
) (
  input  lfsr_t            cur,
  input  logic [7:0]       thr,
  output logic [N_CH-1:0]  noise,
  output logic             pick,
  output lfsr_t            nxt
);
  localparam int STEPS = N_CH + 1;

  lfsr_t chain [STEPS+1];
  assign chain[0] = cur;

  genvar k;
  generate
    for (k = 0; k < STEPS; k++) begin : g_step
      assign chain[k+1] = lfsr_next(chain[k]);
    end
    for (k = 0; k < N_CH; k++) begin : g_chan
      assign noise[k] = (chain[k+1][7:0] < thr);
    end
  endgenerate

  assign pick = chain[STEPS][0];
  assign nxt  = chain[STEPS];
endmodule

// File: rtl/spike_stim_pat_store.sv
module spike_stim_pat_store #(
  parameter int N_CH  = 16,
  parameter int N_PAT = 3,
  parameter int IW    = 2
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [N_CH-1:0] wr_data,
  input  logic [IW-1:0]   rd_idx,
  output logic [N_CH-1:0] rd_data
);
  logic [N_CH-1:0] mem [N_PAT];

  // synchronous write and registered read, no reset: block RAM friendly
  always_ff @(posedge clk) begin
    if (wr_en && (int'(wr_idx) < N_PAT)) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/spike_stim_sched.sv
module spike_stim_sched #(
  parameter int EPOCH_TICKS = 10000,
  parameter int N_PAT       = 3,
  parameter int IW          = 2,
  parameter int SW_W        = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            dyn_en,
  input  logic [SW_W-1:0] sw_epochs,
  input  logic [IW-1:0]   pat_last,
  output logic            emit,
  output logic [IW-1:0]   pat_idx
);
  localparam int TW = (EPOCH_TICKS > 2) ? $clog2(EPOCH_TICKS) : 1;
  localparam logic [TW-1:0] T_LAST  = TW'(EPOCH_TICKS - 1);
  localparam logic [IW-1:0] IDX_MAX = IW'(N_PAT - 1);

  logic            running;
  logic [TW-1:0]   tick;
  logic [SW_W-1:0] seg;
  logic [IW-1:0]   lim;
  logic            seg_end;

  assign lim     = (pat_last > IDX_MAX) ? IDX_MAX : pat_last;
  assign emit    = running && (tick == T_LAST) && !start;
  assign seg_end = (sw_epochs != '0) && (seg == sw_epochs - SW_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      tick    <= '0;
      seg     <= '0;
      pat_idx <= '0;
    end else if (start) begin
      running <= 1'b1;
      tick    <= '0;
      seg     <= '0;
      pat_idx <= '0;
    end else if (running) begin
      tick <= (tick == T_LAST) ? '0 : tick + TW'(1);
      if (emit) begin
        if (!dyn_en) begin
          seg     <= '0;
          pat_idx <= '0;
        end else if (seg_end) begin
          seg     <= '0;
          pat_idx <= (pat_idx >= lim) ? '0 : pat_idx + IW'(1);
        end else if (sw_epochs != '0) begin
          seg <= seg + SW_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/spike_stim_gen.sv
module spike_stim_gen
  import spike_stim_pkg::*;
#(
  parameter int N_CH        = 16,
  parameter int EPOCH_TICKS = 10000,
  parameter int N_PAT       = 3,
  parameter int ECW         = 16,
  parameter int SW_W        = 16,
  localparam int IW         = (N_PAT > 1) ? $clog2(N_PAT) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [15:0]     seed,
  input  logic [7:0]      noise_thr,
  input  logic            dyn_en,
  input  logic [SW_W-1:0] sw_epochs,
  input  logic [IW-1:0]   pat_last,
  input  logic            pat_wr_en,
  input  logic [IW-1:0]   pat_wr_idx,
  input  logic [N_CH-1:0] pat_wr_data,
  output logic [N_CH-1:0] spike,
  output logic            is_pat,
  output logic [ECW-1:0]  epoch_cnt
);
  lfsr_t           lfsr_q;
  lfsr_t           lfsr_nxt;
  logic [N_CH-1:0] noise_img;
  logic [N_CH-1:0] pat_img;
  logic            pick;
  logic            emit;
  logic [IW-1:0]   pat_idx;
  logic            take_pat;

  spike_stim_sched #(
    .EPOCH_TICKS(EPOCH_TICKS), .N_PAT(N_PAT), .IW(IW), .SW_W(SW_W)
  ) u_sched (
    .clk(clk), .rst(rst), .start(start), .dyn_en(dyn_en),
    .sw_epochs(sw_epochs), .pat_last(pat_last),
    .emit(emit), .pat_idx(pat_idx)
  );

  spike_stim_pat_store #(.N_CH(N_CH), .N_PAT(N_PAT), .IW(IW)) u_store (
    .clk(clk), .wr_en(pat_wr_en), .wr_idx(pat_wr_idx), .wr_data(pat_wr_data),
    .rd_idx(pat_idx), .rd_data(pat_img)
  );

  spike_stim_lfsr_fan #(.N_CH(N_CH)) u_fan (
    .cur(lfsr_q), .thr(noise_thr), .noise(noise_img), .pick(pick), .nxt(lfsr_nxt)
  );

  // a pattern epoch is always followed by noise
  assign take_pat = pick && !is_pat;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr_q    <= lfsr_t'(1);
      spike     <= '0;
      is_pat    <= 1'b0;
      epoch_cnt <= '0;
    end else if (start) begin
      lfsr_q    <= seed_fix(seed);
      spike     <= '0;
      is_pat    <= 1'b0;
      epoch_cnt <= '0;
    end else if (emit) begin
      lfsr_q    <= lfsr_nxt;
      spike     <= take_pat ? pat_img : noise_img;
      is_pat    <= take_pat;
      epoch_cnt <= epoch_cnt + ECW'(1);
    end else begin
      spike <= '0;
    end
  end
endmodule

// File: rtl/spike_stim_gen_chk.sv
module spike_stim_gen_chk #(
  parameter int N_CH = 16,
  parameter int ECW  = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [N_CH-1:0] spike,
  input logic            is_pat,
  input logic [ECW-1:0]  epoch_cnt
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst)        armed <= 1'b0;
    else if (start) armed <= 1'b1;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |-> (spike == '0 && !is_pat && epoch_cnt == '0));

  // R2
  single_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (spike != '0) |=> (spike == '0));

  // R2
  spike_on_step_chk: assert property (@(posedge clk) disable iff (rst)
    (spike != '0) |-> (epoch_cnt != $past(epoch_cnt)));

  // R6
  no_double_pat_chk: assert property (@(posedge clk) disable iff (rst)
    (epoch_cnt != $past(epoch_cnt) && !$past(start) && is_pat) |-> !$past(is_pat));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (is_pat != $past(is_pat)) |-> ($past(start) || epoch_cnt != $past(epoch_cnt)));

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (epoch_cnt != $past(epoch_cnt)) |-> ($past(start) || epoch_cnt == $past(epoch_cnt) + ECW'(1)));

  // R11
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (spike == '0 && !is_pat && epoch_cnt == '0));
endmodule

bind spike_stim_gen spike_stim_gen_chk #(.N_CH(N_CH), .ECW(ECW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .spike(spike),
  .is_pat(is_pat), .epoch_cnt(epoch_cnt)
);

// File: tb/spike_stim_gen_bench.sv
module spike_stim_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 16;
  localparam int T   = 24;
  localparam int NP  = 3;
  localparam int ECW = 16;
  localparam int SWW = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [15:0]    seed = 16'h0;
  logic [7:0]     noise_thr = 8'd0;
  logic           dyn_en = 1'b0;
  logic [SWW-1:0] sw_epochs = '0;
  logic [1:0]     pat_last = 2'd0;
  logic           pat_wr_en = 1'b0;
  logic [1:0]     pat_wr_idx = 2'd0;
  logic [N-1:0]   pat_wr_data = '0;
  logic [N-1:0]   spike;
  logic           is_pat;
  logic [ECW-1:0] epoch_cnt;

  spike_stim_gen #(.N_CH(N), .EPOCH_TICKS(T), .N_PAT(NP), .ECW(ECW), .SW_W(SWW)) u_spike_stim_gen (
    .clk(clk), .rst(rst), .start(start), .seed(seed), .noise_thr(noise_thr),
    .dyn_en(dyn_en), .sw_epochs(sw_epochs), .pat_last(pat_last),
    .pat_wr_en(pat_wr_en), .pat_wr_idx(pat_wr_idx), .pat_wr_data(pat_wr_data),
    .spike(spike), .is_pat(is_pat), .epoch_cnt(epoch_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [15:0] m_lfsr;
  bit          m_prev;
  int          m_idx, m_seg, m_ecnt, pat_seen;
  logic [N-1:0] m_pats [NP];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  function automatic logic [15:0] bstep(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic write_pat(input int idx, input logic [N-1:0] d);
    @(negedge clk);
    pat_wr_en = 1'b1; pat_wr_idx = 2'(idx); pat_wr_data = d;
    @(negedge clk);
    pat_wr_en = 1'b0;
    m_pats[idx] = d;
  endtask

  // R11: start taken at the next edge, outputs cleared right after it
  task automatic start_run();
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(spike == '0 && !is_pat, "R11", "spike/flag after start", {15'd0, is_pat, spike}, 32'd0);
    check(epoch_cnt == '0, "R11", "epoch_cnt after start", 32'(epoch_cnt), 32'd0);
    m_lfsr = (seed == 16'h0) ? 16'h0001 : seed;
    m_prev = 0; m_idx = 0; m_seg = 0; m_ecnt = 0;
  endtask

  task automatic run_epochs(input int n, input int wr_ep, input int wr_i, input logic [N-1:0] wr_d);
    for (int e = 0; e < n; e++) begin
      bit quiet = 1;
      for (int c = 1; c <= T; c++) begin
        @(posedge clk);
        @(negedge clk);
        if (e == wr_ep && c == 2) begin
          pat_wr_en = 1'b1; pat_wr_idx = 2'(wr_i); pat_wr_data = wr_d;
        end
        if (e == wr_ep && c == 3) begin
          pat_wr_en = 1'b0;
          m_pats[wr_i] = wr_d; // R12: write done well before the next presentation
        end
        if (c < T) begin
          if (spike != '0 || epoch_cnt != ECW'(m_ecnt)) quiet = 0;
        end else begin
          logic [15:0] s;
          logic [N-1:0] nimg, exp_v;
          bit take;
          int lim;
          string req;
          s = m_lfsr;
          for (int k = 0; k < N; k++) begin
            s = bstep(s);
            nimg[k] = (s[7:0] < noise_thr);
          end
          s = bstep(s);
          take = s[0] && !m_prev;
          exp_v = take ? m_pats[m_idx] : nimg;
          req = m_prev ? "R6" : (take ? (dyn_en ? "R9" : "R8") : "R4");
          check(spike == exp_v, req, "spike vector", 32'(spike), 32'(exp_v));
          check(is_pat == take, take ? "R5" : "R6", "pattern flag", 32'(is_pat), 32'(take));
          m_ecnt++;
          check(epoch_cnt == ECW'(m_ecnt), "R10", "epoch count", 32'(epoch_cnt), 32'(m_ecnt));
          if (take) pat_seen++;
          m_lfsr = s;
          m_prev = take;
          lim = (int'(pat_last) > NP-1) ? NP-1 : int'(pat_last);
          if (!dyn_en) begin
            m_idx = 0; m_seg = 0;
          end else if (sw_epochs != 0) begin
            if (m_seg == int'(sw_epochs) - 1) begin
              m_seg = 0;
              m_idx = (m_idx >= lim) ? 0 : m_idx + 1;
            end else m_seg++;
          end
        end
      end
      check(quiet, "R2", "quiet ticks inside epoch", 32'(quiet), 32'd1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(spike == '0 && !is_pat && epoch_cnt == '0, "R1", "reset state",
          {is_pat, epoch_cnt[14:0], spike}, 32'd0);
    rst = 1'b0;
    // R1: no start yet, nothing may fire for longer than an epoch
    begin
      bit idle_ok = 1;
      for (int c = 0; c < 2*T; c++) begin
        @(negedge clk);
        if (spike != '0 || is_pat || epoch_cnt != '0) idle_ok = 0;
      end
      check(idle_ok, "R1", "idle before start", 32'(idle_ok), 32'd1);
    end

    write_pat(0, 16'h8421);
    write_pat(1, 16'h1248);
    write_pat(2, 16'h0FF0);

    // static mode, sparse noise (R3 R4 R5 R7 R8)
    seed = 16'hACE1; noise_thr = 8'd8; dyn_en = 1'b0;
    pat_seen = 0;
    start_run();
    run_epochs(30, -1, 0, '0);
    check(pat_seen > 0, "R5", "patterns presented", 32'(pat_seen), 32'd1);

    // dynamic mode with a mid-run write to slot 1 (R9 R12)
    seed = 16'h1D2B; dyn_en = 1'b1; sw_epochs = 16'd4; pat_last = 2'd2;
    start_run();
    run_epochs(40, 10, 1, 16'hF00F);

    // out-of-range last slot is clipped (R9)
    seed = 16'h5A5A; sw_epochs = 16'd3; pat_last = 2'd3;
    start_run();
    run_epochs(20, -1, 0, '0);

    // switch count 0 never advances (R9)
    sw_epochs = 16'd0;
    start_run();
    run_epochs(10, -1, 0, '0);

    // zero seed and zero threshold (R3 R4)
    dyn_en = 1'b0; seed = 16'h0000; noise_thr = 8'd0;
    start_run();
    run_epochs(15, -1, 0, '0);

    // dense threshold
    seed = 16'hBEEF; noise_thr = 8'd255;
    start_run();
    run_epochs(10, -1, 0, '0);

    // R11: start taken on the very edge of a presentation
    repeat (T-1) @(posedge clk);
    seed = 16'h7777; noise_thr = 8'd40;
    start_run();
    run_epochs(8, -1, 0, '0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule